// File: doc/BRIEF.md
# Image Pyramid Level Downsampler

The block takes one greyscale frame as a raster-order pixel stream and produces the next coarser pyramid level as a stream of the same form. The output level is half as wide and half as tall as the input. Output pixels sit at the even-row, even-column positions of the input. Each one is a 5x5 binomial-weighted average centred on that position, with per-axis weights 1, 4, 6, 4, 1. The total is scaled by 1/256 with round-to-nearest. No multiplier is used: every weight is built from shifts and adds.

Four on-chip line stores hold the rows above the current one, so each input pixel is supplied exactly once. Where the mask reaches past the frame edge, the nearest edge row or column stands in for the missing one. To build a full pyramid, capture the output stream and pass it through the block again, with the width and height parameters halved at each step.

Top module: `pyrDownsampler`

## Requirements
- R1: While reset is held and right after it, outValid, outSof and outEol are low.
- R2: A complete frame of IMG_W x IMG_H accepted pixels yields exactly (IMG_W/2)*(IMG_H/2) output pixels in raster order. A row of outputs with outEol set holds exactly IMG_W/2 pixels.
- R3: A frame in which every pixel has the same value v yields v at every output, including v = 255.
- R4: The output for centre (r,c) is floor((S + 128) / 256), where S is the sum over i,j in -2..2 of w[i]*w[j]*p(r+i, c+j) and w = {1,4,6,4,1}. An exact half rounds up.
- R5: Mask rows above row 0 take row 0, and mask columns left of column 0 take column 0.
- R6: Mask rows below row IMG_H-1 take row IMG_H-1, and mask columns right of column IMG_W-1 take column IMG_W-1.
- R7: outValid is high for one cycle, registered on the rising edge that accepts the pixel at row min(r+2, IMG_H-1) and column min(c+2, IMG_W-1), and is low after every other edge.
- R8: outSof is high only with the output for centre (0,0). outEol is high only with the output for column IMG_W-2.
- R9: Cycles with inValid low change no state, produce no output, and do not alter later results.
- R10: An accepted pixel with inSof high is taken as row 0, column 0 of a new frame, whatever position the stream had reached.
- R11: An accepted pixel with inEol high ends its row, so the next accepted pixel is column 0 of the following row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input pixel present this cycle |
| inPix | input | PIX_W | Input pixel value, unsigned |
| inSof | input | 1 | Marks the first pixel of a frame |
| inEol | input | 1 | Marks the last pixel of a row |
| outValid | output | 1 | Output pixel present this cycle |
| outPix | output | PIX_W | Filtered, decimated pixel value |
| outSof | output | 1 | Marks the first output pixel of a level |
| outEol | output | 1 | Marks the last output pixel of a row |

## Verification
The bottom-edge substitution and the right-edge substitution can both act on the same accepted pixel. This happens on the last pixel of a frame, which also completes the last output of the final row and must raise outEol in that cycle. Every frame is driven to that last pixel, with flat, ramp, random and single-impulse contents. At that pixel the bench checks the value against its own clamped 5x5 sum, and checks outEol in the same cycle. A start-of-frame marker can also arrive while the position counters are mid-frame. This case is provoked by cutting a frame short, and is judged by comparing every pixel of the following frame to the model.

// File: rtl/pyrPkg.sv
`timescale 1ns/1ps
package pyrPkg;

  // One-cycle strobes passed from control to datapath for each input pixel.
  typedef struct packed {
    logic accept;     // a pixel is taken this cycle
    logic topClamp;   // mask centre is row 0: rows above it repeat row 0
    logic bottomMode; // current row is the last one: it stands in for the row below
    logic leftClamp;  // mask centre is column 0: columns left of it repeat column 0
    logic rightMode;  // current column is the last one: it stands in for the column beyond
    logic emit;       // this pixel completes a mask
    logic firstOut;   // completed mask is centre (0,0)
    logic rowLast;    // completed mask is the last one of its output row
  } pyrStrobes_t;

  // Weights 1,4,6,4,1 applied with shifts and adds only.
  function automatic logic [31:0] binom5(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d,
                                         input logic [31:0] e);
    return a + (b << 2) + (c << 2) + (c << 1) + (d << 2) + e;
  endfunction

endpackage

// File: rtl/pyrLineStore.sv
`timescale 1ns/1ps
module pyrLineStore #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the stored row entry before this cycle's write replaces it.
  assign rdData = mem[addr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
  end

endmodule

// File: rtl/pyrCtrl.sv
`timescale 1ns/1ps
module pyrCtrl
  import pyrPkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int COL_W = $clog2(IMG_W),
  parameter int ROW_W = $clog2(IMG_H)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEol,
  output pyrStrobes_t      strb,
  output logic [COL_W-1:0] colAddr
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);
  localparam logic [COL_W-1:0] COL_TWO  = COL_W'(2);
  localparam logic [ROW_W-1:0] ROW_TWO  = ROW_W'(2);

  logic [COL_W-1:0] colCnt, posX;
  logic [ROW_W-1:0] rowCnt, posY;
  logic rowHit, colHit, lineEnd;

  always_comb begin
    posX    = inSof ? '0 : colCnt;
    posY    = inSof ? '0 : rowCnt;
    lineEnd = inEol || (posX == LAST_COL);
    rowHit  = (!posY[0] && (posY >= ROW_TWO)) || (posY == LAST_ROW);
    colHit  = (!posX[0] && (posX >= COL_TWO)) || (posX == LAST_COL);

    strb.accept     = inValid;
    strb.topClamp   = (posY == ROW_TWO);
    strb.bottomMode = (posY == LAST_ROW);
    strb.leftClamp  = (posX == COL_TWO);
    strb.rightMode  = (posX == LAST_COL);
    strb.emit       = inValid && rowHit && colHit;
    strb.firstOut   = (posY == ROW_TWO) && (posX == COL_TWO);
    strb.rowLast    = (posX == LAST_COL);
    colAddr         = posX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (inValid) begin
      if (lineEnd) begin
        colCnt <= '0;
        rowCnt <= (posY == LAST_ROW) ? '0 : posY + 1'b1;
      end else begin
        colCnt <= posX + 1'b1;
        rowCnt <= posY;
      end
    end
  end

  AST_POS_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    (colCnt <= LAST_COL) && (rowCnt <= LAST_ROW)); // R2

  AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(colCnt) && $stable(rowCnt)); // R9

endmodule

// File: rtl/pyrDatapath.sv
`timescale 1ns/1ps
module pyrDatapath
  import pyrPkg::*;
#(
  parameter int IMG_W = 64,
  parameter int PIX_W = 8,
  parameter int COL_W = $clog2(IMG_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  pyrStrobes_t      strb,
  input  logic [COL_W-1:0] colAddr,
  input  logic [PIX_W-1:0] inPix,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outSof,
  output logic             outEol
);

  localparam int LINES  = 4;
  localparam int VSUM_W = PIX_W + 4;
  localparam int SUM_W  = PIX_W + 8;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(128);

  // tap[k] holds the pixel of row (current - 1 - k) at this column.
  logic [LINES-1:0][PIX_W-1:0] tap;

  for (genvar k = 0; k < LINES; k++) begin : gLine
    logic [PIX_W-1:0] chainIn;
    if (k == 0) begin : gHead
      assign chainIn = inPix;
    end else begin : gBody
      assign chainIn = tap[k-1];
    end
    pyrLineStore #(
      .DEPTH (IMG_W),
      .DATA_W(PIX_W),
      .ADDR_W(COL_W)
    ) uStore (
      .clk   (clk),
      .wrEn  (strb.accept),
      .addr  (colAddr),
      .wrData(chainIn),
      .rdData(tap[k])
    );
  end

  // Vertical pass: choose the five rows the mask needs, then weight them.
  logic [PIX_W-1:0] va, vb, vc, vd, ve;
  logic [VSUM_W-1:0] vSum;

  always_comb begin
    if (strb.bottomMode) begin
      va = tap[2]; vb = tap[1]; vc = tap[0]; vd = inPix; ve = inPix;
    end else if (strb.topClamp) begin
      va = tap[1]; vb = tap[1]; vc = tap[1]; vd = tap[0]; ve = inPix;
    end else begin
      va = tap[3]; vb = tap[2]; vc = tap[1]; vd = tap[0]; ve = inPix;
    end
    vSum = VSUM_W'(binom5(32'(va), 32'(vb), 32'(vc), 32'(vd), 32'(ve)));
  end

  // Horizontal pass over the most recent column sums of this row.
  logic [LINES-1:0][VSUM_W-1:0] hist;
  logic [VSUM_W-1:0] ha, hb, hc, hd, he;
  logic [SUM_W-1:0]  total;
  logic [PIX_W-1:0]  rounded;

  always_comb begin
    if (strb.rightMode) begin
      ha = hist[2]; hb = hist[1]; hc = hist[0]; hd = vSum; he = vSum;
    end else if (strb.leftClamp) begin
      ha = hist[1]; hb = hist[1]; hc = hist[1]; hd = hist[0]; he = vSum;
    end else begin
      ha = hist[3]; hb = hist[2]; hc = hist[1]; hd = hist[0]; he = vSum;
    end
    total   = SUM_W'(binom5(32'(ha), 32'(hb), 32'(hc), 32'(hd), 32'(he)));
    rounded = PIX_W'((total + HALF) >> 8);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else if (strb.accept) begin
      hist <= {hist[LINES-2:0], vSum};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= strb.emit;
      outSof   <= strb.emit && strb.firstOut;
      outEol   <= strb.emit && strb.rowLast;
      if (strb.emit) outPix <= rounded;
    end
  end

  AST_VALID_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.accept)); // R7

  AST_EDGE_ROWS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.topClamp |-> !strb.bottomMode); // R5

  AST_EDGE_COLS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.leftClamp |-> !strb.rightMode); // R6

endmodule

// File: rtl/pyrDownsampler.sv
`timescale 1ns/1ps
module pyrDownsampler
  import pyrPkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inSof,
  input  logic             inEol,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outSof,
  output logic             outEol
);

  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam logic [COL_W-1:0] ROW_OUTS_M1 = COL_W'(IMG_W / 2 - 1);

  pyrStrobes_t      strb;
  logic [COL_W-1:0] colAddr;

  pyrCtrl #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H),
    .COL_W(COL_W),
    .ROW_W(ROW_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inSof  (inSof),
    .inEol  (inEol),
    .strb   (strb),
    .colAddr(colAddr)
  );

  pyrDatapath #(
    .IMG_W(IMG_W),
    .PIX_W(PIX_W),
    .COL_W(COL_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .colAddr (colAddr),
    .inPix   (inPix),
    .outValid(outValid),
    .outPix  (outPix),
    .outSof  (outSof),
    .outEol  (outEol)
  );

  // Outputs seen earlier in the current output row.
  logic [COL_W-1:0] rowOuts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOuts <= '0;
    end else if (outValid) begin
      if (outEol)      rowOuts <= '0;
      else if (outSof) rowOuts <= COL_W'(1);
      else             rowOuts <= rowOuts + 1'b1;
    end
  end

  AST_ROW_OUTPUT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEol && !outSof) |-> (rowOuts == ROW_OUTS_M1)); // R2

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid); // R8

  AST_EOL_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outEol |-> outValid); // R8

endmodule

// File: tb/tb_pyrDownsampler.sv
`timescale 1ns/1ps
module tb_pyrDownsampler;

  localparam int W = 8;
  localparam int H = 6;
  localparam int OUTS = (W / 2) * (H / 2);

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inPix;
  logic       inSof;
  logic       inEol;
  logic       outValid;
  logic [7:0] outPix;
  logic       outSof;
  logic       outEol;

  always #2 clk = ~clk;

  pyrDownsampler #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPix(inPix),
    .inSof(inSof), .inEol(inEol), .outValid(outValid), .outPix(outPix),
    .outSof(outSof), .outEol(outEol)
  );

  int nChk  = 0;
  int nFail = 0;
  int outSeen;
  int fr [H][W];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[7:0]);
  endfunction

  function automatic int clampI(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int modelPix(int cr, int cc);
    int w [5] = '{1, 4, 6, 4, 1};
    int s = 0;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        s += w[i] * w[j] * fr[clampI(cr + i - 2, H - 1)][clampI(cc + j - 2, W - 1)];
    return (s + 128) / 256;
  endfunction

  function automatic bit hitAt(int p, int last);
    return ((p % 2 == 0) && (p >= 2)) || (p == last);
  endfunction

  function automatic int centreOf(int p, int last);
    return (p == last) ? last - 1 : p - 2;
  endfunction

  function automatic string posTag(int cr, int cc);
    if (cr == 0 || cc == 0) return "R5";
    if (cr == H - 2 || cc == W - 2) return "R6";
    return "R4";
  endfunction

  // Drive one pixel, let the edge accept it, then sample the registered outputs.
  task automatic step(int val, bit sof, bit eol, bit doChk, bit expV, int expP,
                      bit expS, bit expE, string pTag);
    inValid = 1'b1; inPix = 8'(val); inSof = sof; inEol = eol;
    @(posedge clk); #1;
    if (outValid === 1'b1) outSeen++;
    if (doChk) begin
      chk("R7", "outValid", int'(outValid), int'(expV));
      if (expV) begin
        chk(pTag, "outPix", int'(outPix), expP);
        chk("R8", "outSof", int'(outSof), int'(expS));
        chk("R8", "outEol", int'(outEol), int'(expE));
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEol = 1'b0;
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      inPix = 8'(nextRand());
      @(posedge clk); #1;
      chk("R9", "outValid during idle", int'(outValid), 0);
      @(negedge clk);
    end
  endtask

  task automatic runFrame(string valTag, bit gaps);
    outSeen = 0;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        bit ev = hitAt(y, H - 1) && hitAt(x, W - 1);
        int cr = centreOf(y, H - 1);
        int cc = centreOf(x, W - 1);
        string tg = (valTag != "") ? valTag : posTag(cr, cc);
        if (gaps && nextRand() < 90) idle(1 + (nextRand() % 2));
        step(fr[y][x], (y == 0 && x == 0), (x == W - 1), 1'b1, ev,
             ev ? modelPix(cr, cc) : 0, ev && cr == 0 && cc == 0,
             ev && cc == W - 2, tg);
      end
    end
    chk("R2", "outputs per frame", outSeen, OUTS);
  endtask

  task automatic testReset();
    rstN = 1'b0; inValid = 1'b0; inPix = '0; inSof = 1'b0; inEol = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "outSof in reset", int'(outSof), 0);
    chk("R1", "outEol in reset", int'(outEol), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "outValid after reset", int'(outValid), 0);
    @(negedge clk);
  endtask

  task automatic testFlat(int v);
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) fr[y][x] = v;
    runFrame("R3", 1'b0);
  endtask

  task automatic testRamp();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) fr[y][x] = (x * 37 + y * 53) % 256;
    runFrame("", 1'b0);
  endtask

  task automatic testHalfRounding();
    // 36 * 32 / 256 = 4.5, so the centre (2,2) must read 5.
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) fr[y][x] = 0;
    fr[2][2] = 32;
    chk("R4", "model half case", modelPix(2, 2), 5);
    runFrame("R4", 1'b0);
  endtask

  task automatic testRandom(bit gaps, string tag);
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) fr[y][x] = nextRand();
    runFrame(tag, gaps);
  endtask

  task automatic testResync();
    for (int k = 0; k < 13; k++) step(nextRand(), (k == 0), 1'b0, 1'b0, 0, 0, 0, 0, "");
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) fr[y][x] = nextRand();
    runFrame("R10", 1'b1);
  endtask

  task automatic testEarlyEol();
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) fr[y][x] = nextRand();
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < W; x++)
        step(fr[y][x], (y == 0 && x == 0), (x == W - 1), 1'b1, 0, 0, 0, 0, "R11");
    // Row 2 cut after three pixels; the third completes centre (0,0).
    step(fr[2][0], 0, 0, 1'b1, 0, 0, 0, 0, "R11");
    step(fr[2][1], 0, 0, 1'b1, 0, 0, 0, 0, "R11");
    step(fr[2][2], 0, 1, 1'b1, 1, modelPix(0, 0), 1, 0, "R11");
    for (int x = 0; x < W; x++)
      step(fr[3][x], 0, (x == W - 1), 1'b1, 0, 0, 0, 0, "R11");
    step(fr[4][0], 0, 0, 1'b1, 0, 0, 0, 0, "R11");
    step(fr[4][1], 0, 0, 1'b1, 0, 0, 0, 0, "R11");
    step(fr[4][2], 0, 0, 1'b1, 1, modelPix(2, 0), 0, 0, "R11");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #200000;
    nChk++;
    nFail++;
    $display("FAIL R7 watchdog expired: got 0 expected 1");
    finishRun();
  end

  initial begin
    testReset();
    testFlat(77);
    testFlat(255);
    testRamp();
    testHalfRounding();
    testRandom(1'b0, "");
    testRandom(1'b1, "R9");
    testResync();
    testEarlyEol();
    testRandom(1'b0, "");
    finishRun();
  end

endmodule